// File: doc/BRIEF.md
# Sixteen-Bit Timer with Clear-on-Match

This block is a 16-bit up-counter that advances once for each pulse on a tick input. An external prescaler drives that input. A 4-bit mode field picks how the count ends. In free-running mode the count passes 0xFFFF and wraps to zero. In the two clear-on-match modes the count returns to zero at a TOP value. TOP is held either in the compare-A register or in the capture register, and the mode code decides which one is used.

Software loads the counter, the compare-A register and the capture register through one write port that has a 2-bit register select. Three sticky event flags record a wrap past the maximum, a compare-A match and a capture-register match. A flag is cleared by writing a one to its bit through the flag select, or by pulsing its interrupt-acknowledge line. Each interrupt request is its flag gated by its enable. One compare output pin can toggle on every compare-A match. In the clear-on-compare mode this gives a square wave whose period is 2*(TOP+1) ticks.

Top module: `ctc_timer16`

## Requirements
- R1: While rst is high, count, the compare-A register, the capture register, all three flags and oc_a are driven to zero.
- R2: When tick is low and no counter write happens, count holds its value. When tick is high, count steps by one, unless R4 to R6 say otherwise.
- R3: A write with wr_sel=0 loads wr_data into count on the next edge and overrides tick. In that cycle no match, wrap or toggle event is raised.
- R4: Every mode code other than 4 and 12 is free-running. On a tick the count goes from 0xFFFF to 0x0000, and a compare-A match never clears the count.
- R5: With mode 4, a tick while count equals the compare-A register (loaded with wr_sel=1) makes count 0.
- R6: With mode 12, a tick while count equals the capture register (loaded with wr_sel=2) makes count 0.
- R7: flags[0] (overflow) is set on every tick at which count is 0xFFFF and no counter write happens. It is set at the same edge where count becomes zero, in every mode.
- R8: flags[1] (compare-A) is set on every tick at which count equals the compare-A register, in every mode, including mode 0.
- R9: flags[2] (capture match) is set on a tick at which count equals the capture register, and only in mode 12.
- R10: A write with wr_sel=2'd3 clears each flag whose bit in wr_data[2:0] is 1. A high bit of irq_ack clears the matching flag. When a set and a clear occur in the same cycle, the set wins.
- R11: When com_a=2'b01, oc_a inverts on every compare-A match event. Any other com_a value leaves oc_a unchanged.
- R12: irq[i] equals flags[i] AND irq_en[i] for each of the three bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable pulse from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 counter, 1 compare-A, 2 capture, 3 flag clear |
| wr_data | input | 16 | Write data |
| mode | input | 4 | Waveform mode code (0, 4, 12; others act as 0) |
| com_a | input | 2 | Compare output action; 01 means toggle |
| irq_en | input | 3 | Interrupt enables {capture, compare-A, overflow} |
| irq_ack | input | 3 | Interrupt acknowledge pulses that clear flags |
| count | output | 16 | Counter value |
| flags | output | 3 | Sticky flags {capture, compare-A, overflow} |
| irq | output | 3 | Interrupt requests |
| oc_a | output | 1 | Compare output pin |

## Verification
The properties assume that mode, com_a and the holding registers stay steady across the edge that follows a counted tick. They also assume that rst is held for at least one edge at start-up so that no register carries an unknown value. The stimulus drives every input just after a falling edge and changes the mode only every few hundred cycles. Compare and capture values stay small, so clear-on-match events happen often. Counter loads land just below 0xFFFF, so the wrap and overflow path is exercised in every mode.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  typedef enum logic [1:0] {
    TS_FREE = 2'd0,
    TS_OCA  = 2'd1,
    TS_ICP  = 2'd2
  } top_sel_e;

  localparam int NFLAG = 3;
  localparam int FLG_OVF = 0;
  localparam int FLG_CMP = 1;
  localparam int FLG_CAP = 2;

  localparam logic [1:0] SEL_CNT = 2'd0;
  localparam logic [1:0] SEL_CMP = 2'd1;
  localparam logic [1:0] SEL_CAP = 2'd2;
  localparam logic [1:0] SEL_FLG = 2'd3;

  localparam logic [1:0] COM_TOGGLE = 2'b01;

  function automatic top_sel_e decode_mode(input logic [3:0] m);
    case (m)
      4'd4:    return TS_OCA;
      4'd12:   return TS_ICP;
      default: return TS_FREE;
    endcase
  endfunction

endpackage

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  top_sel_e         top_sel,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0] cap_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ev_cmp,
  output logic             ev_cap,
  output logic             ev_wrap
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic adv;
  logic hit_top;

  assign adv     = tick & ~load;
  assign ev_cmp  = adv && (cnt_q == cmp_val);
  assign ev_cap  = adv && (cnt_q == cap_val);
  assign ev_wrap = adv && (cnt_q == CNT_MAX);

  always_comb begin
    case (top_sel)
      TS_OCA:  hit_top = ev_cmp;
      TS_ICP:  hit_top = ev_cap;
      default: hit_top = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (adv) begin
      if (hit_top || ev_wrap) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cmp_q,
  output logic [CNT_W-1:0] cap_q
);

  localparam int NREG = 2;

  logic [CNT_W-1:0] hold_q [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_hold
    localparam logic [1:0] MY_SEL = (k == 0) ? SEL_CMP : SEL_CAP;
    always_ff @(posedge clk) begin
      if (rst)                            hold_q[k] <= '0;
      else if (wr_en && wr_sel == MY_SEL) hold_q[k] <= wr_data;
    end
  end

  assign cmp_q = hold_q[0];
  assign cap_q = hold_q[1];

endmodule

// File: rtl/tmr_flags.sv
`timescale 1ns/1ps
module tmr_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] wclr,
  input  logic [N-1:0] ack,
  input  logic [N-1:0] ien,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] irq
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                    flag_q[i] <= 1'b0;
      else if (set[i])            flag_q[i] <= 1'b1;
      else if (wclr[i] || ack[i]) flag_q[i] <= 1'b0;
    end
    assign irq[i] = flag_q[i] & ien[i];
  end

endmodule

// File: rtl/tmr_ocpin.sv
`timescale 1ns/1ps
module tmr_ocpin
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ev,
  input  logic [1:0] com,
  output logic       oc_q
);

  always_ff @(posedge clk) begin
    if (rst)                           oc_q <= 1'b0;
    else if (ev && com == COM_TOGGLE)  oc_q <= ~oc_q;
  end

endmodule

// File: rtl/ctc_timer16.sv
`timescale 1ns/1ps
module ctc_timer16
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [MODE_W-1:0] mode,
  input  logic [1:0]        com_a,
  input  logic [NFLAG-1:0]  irq_en,
  input  logic [NFLAG-1:0]  irq_ack,
  output logic [CNT_W-1:0]  count,
  output logic [NFLAG-1:0]  flags,
  output logic [NFLAG-1:0]  irq,
  output logic              oc_a
);

  top_sel_e         top_sel;
  logic             cnt_load;
  logic [CNT_W-1:0] ocra_q;
  logic [CNT_W-1:0] icr_q;
  logic             ev_cmp, ev_cap, ev_wrap;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_wclr;
  logic [3:0]       mode4;

  assign mode4    = 4'(mode);
  assign top_sel  = decode_mode(mode4);
  assign cnt_load = wr_en && (wr_sel == SEL_CNT);

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cmp_q   (ocra_q),
    .cap_q   (icr_q)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (cnt_load),
    .load_val (wr_data),
    .top_sel  (top_sel),
    .cmp_val  (ocra_q),
    .cap_val  (icr_q),
    .cnt_q    (count),
    .ev_cmp   (ev_cmp),
    .ev_cap   (ev_cap),
    .ev_wrap  (ev_wrap)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[FLG_OVF] = ev_wrap;
    flag_set[FLG_CMP] = ev_cmp;
    flag_set[FLG_CAP] = ev_cap && (top_sel == TS_ICP);
    flag_wclr         = (wr_en && wr_sel == SEL_FLG) ? wr_data[NFLAG-1:0] : '0;
  end

  tmr_flags #(.N(NFLAG)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set    (flag_set),
    .wclr   (flag_wclr),
    .ack    (irq_ack),
    .ien    (irq_en),
    .flag_q (flags),
    .irq    (irq)
  );

  tmr_ocpin u_oc (
    .clk  (clk),
    .rst  (rst),
    .ev   (ev_cmp),
    .com  (com_a),
    .oc_q (oc_a)
  );

endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk #(
  parameter int CNT_W  = 16,
  parameter int MODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [CNT_W-1:0]  wr_data,
  input logic [MODE_W-1:0] mode,
  input logic [1:0]        com_a,
  input logic [CNT_W-1:0]  count,
  input logic [2:0]        flags,
  input logic              oc_a,
  input logic [CNT_W-1:0]  ocra,
  input logic [CNT_W-1:0]  icr
);

  logic ld;
  assign ld = wr_en && (wr_sel == 2'd0);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld) |=> $stable(count));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> (count == $past(wr_data)));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && count == {CNT_W{1'b1}}) |=> (count == '0 && flags[0]));

  // R5
  ctc_oca_chk: assert property (@(posedge clk) disable iff (rst)
    (MODE_W'(4) == mode && tick && !ld && count == ocra) |=> (count == '0 && flags[1]));

  // R6
  ctc_icp_chk: assert property (@(posedge clk) disable iff (rst)
    (MODE_W'(12) == mode && tick && !ld && count == icr) |=> (count == '0 && flags[2]));

  // R11
  toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && count == ocra && com_a == 2'b01) |=> (oc_a != $past(oc_a)));

  // R10
  cap_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3 && wr_data[2] && mode != MODE_W'(12)) |=> !flags[2]);

endmodule

bind ctc_timer16 tmr_chk #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .mode    (mode),
  .com_a   (com_a),
  .count   (count),
  .flags   (flags),
  .oc_a    (oc_a),
  .ocra    (ocra_q),
  .icr     (icr_q)
);

// File: tb/test_ctc_timer16.sv
`timescale 1ns/1ps
module test_ctc_timer16;

  localparam int CLK_PERIOD = 10;
  localparam int NCYC       = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [3:0]  mode = 4'd0;
  logic [1:0]  com_a = 2'd0;
  logic [2:0]  irq_en = 3'd0;
  logic [2:0]  irq_ack = 3'd0;
  logic [15:0] count;
  logic [2:0]  flags;
  logic [2:0]  irq;
  logic        oc_a;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_cnt, m_ocra, m_icr;
  logic [2:0]  m_flg;
  logic        m_oc;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctc_timer16 i_ctc_timer16 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .mode(mode), .com_a(com_a), .irq_en(irq_en),
    .irq_ack(irq_ack), .count(count), .flags(flags), .irq(irq), .oc_a(oc_a)
  );

  function automatic logic [1:0] dec(input logic [3:0] m);
    return (m == 4'd4) ? 2'd1 : (m == 4'd12) ? 2'd2 : 2'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 R3 R4 R5 R6 count", 32'(count), 32'(m_cnt));
    chk("R7 R8 R9 R10 flags", 32'(flags), 32'(m_flg));
    chk("R11 oc_a", 32'(oc_a), 32'(m_oc));
    chk("R12 irq", 32'(irq), 32'(m_flg & irq_en));
  endtask

  task automatic run_cycle();
    logic wc, ma, mi, mw;
    logic [1:0] md;
    logic [2:0] set, clr;
    wc = wr_en && wr_sel == 2'd0;
    md = dec(mode);
    ma = tick && !wc && m_cnt == m_ocra;
    mi = tick && !wc && m_cnt == m_icr;
    mw = tick && !wc && m_cnt == 16'hFFFF;
    set = {md == 2'd2 && mi, ma, mw};
    clr = ((wr_en && wr_sel == 2'd3) ? wr_data[2:0] : 3'd0) | irq_ack;
    if (ma && com_a == 2'b01) m_oc = ~m_oc;
    if (wc) m_cnt = wr_data;
    else if (tick) begin
      if ((md == 2'd1 && ma) || (md == 2'd2 && mi) || mw) m_cnt = 16'd0;
      else m_cnt = m_cnt + 16'd1;
    end
    if (wr_en && wr_sel == 2'd1) m_ocra = wr_data;
    if (wr_en && wr_sel == 2'd2) m_icr = wr_data;
    m_flg = (m_flg & ~clr) | set;
    @(negedge clk);
    compare_all();
  endtask

  task automatic write_reg(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d; tick = 1'b0;
    run_cycle();
    wr_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_cnt = '0; m_ocra = '0; m_icr = '0; m_flg = '0; m_oc = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 count", 32'(count), 0);
    chk("R1 flags", 32'(flags), 0);
    chk("R1 oc_a", 32'(oc_a), 0);
    rst = 1'b0;
    run_cycle();

    // R5 R11: square wave in clear-on-compare mode, TOP=3
    mode = 4'd4; com_a = 2'b01; irq_en = 3'b111;
    write_reg(2'd1, 16'd3);
    tick = 1'b1;
    repeat (24) run_cycle();

    // R4 R7: wrap in free-running mode, compare match does not clear
    mode = 4'd0;
    write_reg(2'd0, 16'hFFFD);
    tick = 1'b1;
    repeat (6) run_cycle();
    write_reg(2'd3, 16'd7);

    // R6 R9: clear on capture register
    mode = 4'd12;
    write_reg(2'd2, 16'd5);
    write_reg(2'd0, 16'd0);
    tick = 1'b1;
    repeat (20) run_cycle();

    // R10: set wins over simultaneous clear
    write_reg(2'd0, 16'd5);
    tick = 1'b1; irq_ack = 3'b100;
    run_cycle();
    irq_ack = 3'd0;

    for (int c = 0; c < NCYC; c++) begin
      if (c % 300 == 0) begin
        case ($urandom % 5)
          0: mode = 4'd0;
          1: mode = 4'd4;
          2: mode = 4'd12;
          3: mode = 4'($urandom % 16);
          default: mode = 4'd4;
        endcase
        com_a  = ($urandom % 3 == 0) ? 2'($urandom % 4) : 2'b01;
        irq_en = 3'($urandom % 8);
      end
      tick  = ($urandom % 4) != 0;
      wr_en = ($urandom % 100) < 12;
      wr_sel = 2'($urandom % 4);
      case (wr_sel)
        2'd0: wr_data = ($urandom % 2 == 0) ? (16'hFFF0 + 16'($urandom % 16))
                                            : 16'($urandom % 24);
        2'd3: wr_data = 16'($urandom % 8);
        default: wr_data = 16'($urandom % 24);
      endcase
      irq_ack = ($urandom % 8 == 0) ? 3'($urandom % 8) : 3'd0;
      run_cycle();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule